// File: doc/BRIEF.md
# Watchdog Reset Pulse Shaper with Keyed Flags

This block holds the 32-bit setting that governs the reset pulse a watchdog sends out, and it produces that pulse. The low field gives the pulse length in ticks. Two flags near the top of the word choose the level the pulse takes when asserted and how the pad is driven. These flags cannot be changed by ordinary bit writes. They move only when the top byte of a write carries one of four key values. Every write replaces the length field and leaves all other bits as they were.

A single trigger input starts a pulse; the counter that decides when the watchdog fires sits outside this block. While a pulse runs, the output sits at the chosen asserted level. The output-enable models either a line that is always driven or one that is driven only while asserted and released otherwise. A tick input paces the pulse, so the same block can run from a slow time base.

Top module: `wdog_rst_shaper`

## Requirements
- R1: After reset the register reads 0x000000FF (length 255, asserted level low, open-drain), no pulse is active, `rst_out` is 1 and `rst_oe` is 0.
- R2: A write loads `cfg_wdata[19:0]` into the length field; bits [29:20] always read 0, and bits [31:30] are not taken from the written data.
- R3: A write whose top byte (`cfg_wdata[31:24]`) is 0xA5 sets bit 31, so the pulse is asserted high.
- R4: A write whose top byte is 0x5A clears bit 31, so the pulse is asserted low.
- R5: A write whose top byte is 0xA8 sets bit 30, selecting push-pull drive.
- R6: A write whose top byte is 0x8A clears bit 30, selecting open-drain drive.
- R7: A write with any other top byte, zero included, leaves bits 31 and 30 unchanged.
- R8: A trigger seen while idle makes `pulse_active` rise at the next clock edge; the pulse then lasts for exactly length+1 clock edges at which `tick` is 1, and edges without `tick` do not shorten it.
- R9: A trigger that arrives while a pulse is active is ignored and does not lengthen or restart it.
- R10: While `pulse_active` is 1, `rst_out` equals bit 31; otherwise `rst_out` is the inverse of bit 31.
- R11: With bit 30 set, `rst_oe` is always 1; with bit 30 clear, `rst_oe` equals `pulse_active`.
- R12: The length is captured when the pulse starts: a write during a pulse does not change that pulse's duration, and a length of 0 gives a one-tick pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data: key byte in [31:24], length in [19:0] |
| cfg_rdata | output | 32 | Current configuration word: {level flag, drive flag, zeros, length} |
| tick | input | 1 | Time-base enable that paces the pulse |
| trig | input | 1 | Starts a pulse when idle |
| pulse_active | output | 1 | High while the reset pulse is being asserted |
| rst_out | output | 1 | Reset line level |
| rst_oe | output | 1 | Output-enable for the reset pad |

## Verification
The hardest states to reach are the flag transitions for every possible top byte starting from each of the four flag combinations. The key values sit among 256 byte codes, and a write that fails to hold a flag looks just like one that sets it when the flag already has that value. The stimulus first forces each of the four flag states with keys, then sweeps all 256 top bytes. Each write carries a different length and junk in bits [23:20], so a stray bit copy shows up in the readback. Pulse lengths are measured by counting the ticking edges while the pulse is active. Mid-pulse retriggers and mid-pulse length writes are placed inside irregular tick patterns.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned KEY_MSB = 31;
  localparam int unsigned KEY_LSB = 24;
  localparam int unsigned LVL_BIT = 31;
  localparam int unsigned DRV_BIT = 30;

  localparam logic [7:0] KEY_LVL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_LVL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef enum logic [1:0] {
    FLAG_KEEP = 2'd0,
    FLAG_SET  = 2'd1,
    FLAG_CLR  = 2'd2
  } flag_op_e;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_BUSY = 1'b1
  } pulse_state_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_rst_cfg.sv
module wdog_rst_cfg
  import wdog_rst_pkg::*;
#(
  parameter int unsigned     LEN_W   = 20,
  parameter logic [LEN_W-1:0] RST_LEN = LEN_W'(255)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [LEN_W-1:0] len_q,
  output logic             lvl_q,
  output logic             drv_q,
  output logic [CFG_W-1:0] rd_word
);
  localparam int unsigned PAD_W = CFG_W - 2 - LEN_W;

  logic [7:0]       key;
  flag_op_e         lvl_op, drv_op;
  logic [LEN_W-1:0] len_d;
  logic             lvl_d, drv_d;

  assign key = wr_data[KEY_MSB:KEY_LSB];

  always_comb begin
    lvl_op = FLAG_KEEP;
    drv_op = FLAG_KEEP;
    unique case (key)
      KEY_LVL_HIGH: lvl_op = FLAG_SET;
      KEY_LVL_LOW:  lvl_op = FLAG_CLR;
      KEY_DRV_PP:   drv_op = FLAG_SET;
      KEY_DRV_OD:   drv_op = FLAG_CLR;
      default: ;
    endcase
  end

  function automatic logic apply_op(input flag_op_e op, input logic cur);
    case (op)
      FLAG_SET: apply_op = 1'b1;
      FLAG_CLR: apply_op = 1'b0;
      default:  apply_op = cur;
    endcase
  endfunction

  always_comb begin
    len_d = len_q;
    lvl_d = lvl_q;
    drv_d = drv_q;
    if (wr_en) begin
      len_d = wr_data[LEN_W-1:0];
      lvl_d = apply_op(lvl_op, lvl_q);
      drv_d = apply_op(drv_op, drv_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= RST_LEN;
      lvl_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (wr_en) begin
      len_q <= len_d;
      lvl_q <= lvl_d;
      drv_q <= drv_d;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_word = {lvl_q, drv_q, {PAD_W{1'b0}}, len_q};
    end else begin : g_nopad
      assign rd_word = {lvl_q, drv_q, len_q};
    end
  endgenerate
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_rst_pkg::*;
#(
  parameter int unsigned LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  pulse_state_e     state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_IDLE: begin
        if (start) begin
          state_d = PS_BUSY;
          cnt_d   = len;
        end
      end
      PS_BUSY: begin
        if (tick) begin
          if (cnt_q == '0) state_d = PS_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  assign cnt_en = (state_q == PS_IDLE) ? start : tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == PS_BUSY);
endmodule

// File: rtl/wdog_rst_pad.sv
module wdog_rst_pad (
  input  logic busy,
  input  logic lvl_high,
  input  logic push_pull,
  output logic pin,
  output logic pin_oe
);
  always_comb begin
    pin    = busy ? lvl_high : ~lvl_high;
    pin_oe = push_pull | busy;
  end
endmodule

// File: rtl/wdog_rst_shaper.sv
module wdog_rst_shaper
  import wdog_rst_pkg::*;
#(
  parameter int unsigned LEN_W       = 20,
  parameter int unsigned RST_LEN     = 255,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        tick,
  input  logic        trig,
  output logic        pulse_active,
  output logic        rst_out,
  output logic        rst_oe
);
  logic             rst_n_sync;
  logic [LEN_W-1:0] len_q;
  logic             lvl_q, drv_q;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  wdog_rst_cfg #(.LEN_W(LEN_W), .RST_LEN(LEN_W'(RST_LEN))) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .len_q   (len_q),
    .lvl_q   (lvl_q),
    .drv_q   (drv_q),
    .rd_word (cfg_rdata)
  );

  wdog_rst_pulse #(.LEN_W(LEN_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .start (trig),
    .tick  (tick),
    .len   (len_q),
    .busy  (pulse_active)
  );

  wdog_rst_pad u_pad (
    .busy      (pulse_active),
    .lvl_high  (lvl_q),
    .push_pull (drv_q),
    .pin       (rst_out),
    .pin_oe    (rst_oe)
  );
endmodule

// File: rtl/wdog_rst_shaper_chk.sv
module wdog_rst_shaper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        tick,
  input logic        trig,
  input logic        pulse_active,
  input logic        rst_out,
  input logic        rst_oe
);
  logic [7:0] key;
  logic       is_key;
  assign key    = cfg_wdata[31:24];
  assign is_key = (key == 8'hA5) || (key == 8'h5A) || (key == 8'hA8) || (key == 8'h8A);

  p_len_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[19:0] == $past(cfg_wdata[19:0]));
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[29:20] == 10'd0);
  p_lvl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && key == 8'hA5) |=> cfg_rdata[31]);
  p_lvl_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && key == 8'h5A) |=> !cfg_rdata[31]);
  p_drv_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && key == 8'hA8) |=> cfg_rdata[30]);
  p_drv_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && key == 8'h8A) |=> !cfg_rdata[30]);
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || !is_key) |=> cfg_rdata[31:30] == $past(cfg_rdata[31:30]));
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_active && trig) |=> pulse_active);
  p_hold_notick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && !tick) |=> pulse_active);
  p_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out == (pulse_active ? cfg_rdata[31] : !cfg_rdata[31]));
  p_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_oe == (cfg_rdata[30] | pulse_active));
endmodule

bind wdog_rst_shaper wdog_rst_shaper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .tick         (tick),
  .trig         (trig),
  .pulse_active (pulse_active),
  .rst_out      (rst_out),
  .rst_oe       (rst_oe)
);

// File: tb/wdog_rst_shaper_bench.sv
module wdog_rst_shaper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick = 1'b0;
  logic        trig = 1'b0;
  logic        pulse_active, rst_out, rst_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic        m_lvl, m_drv;
  logic [19:0] m_len;

  always #10 clk = ~clk;

  wdog_rst_shaper u_wdog_rst_shaper (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick(tick), .trig(trig),
    .pulse_active(pulse_active), .rst_out(rst_out), .rst_oe(rst_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    return {m_lvl, m_drv, 10'd0, m_len};
  endfunction

  task automatic check_pins(input string req);
    check({req, " level"}, {31'd0, rst_out}, {31'd0, pulse_active ? m_lvl : ~m_lvl});
    check({req, " oe"},    {31'd0, rst_oe},  {31'd0, m_drv | pulse_active});
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
    m_len = d[19:0];
    case (d[31:24])
      8'hA5: m_lvl = 1'b1;
      8'h5A: m_lvl = 1'b0;
      8'hA8: m_drv = 1'b1;
      8'h8A: m_drv = 1'b0;
      default: ;
    endcase
  endtask

  // pattern: 0 = tick always, 1 = every third edge, 2 = alternate
  function automatic logic tick_pat(input int pat, input int i);
    case (pat)
      1: return (i % 3) == 2;
      2: return i[0];
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_pulse(input int pat, input int exp_ticks, input bit retrig,
                           input bit midwrite, input string req);
    int ticks = 0;
    int i = 0;
    @(negedge clk);
    trig = 1'b1; tick = 1'b0;
    @(negedge clk);
    trig = 1'b0;
    check({req, " start"}, {31'd0, pulse_active}, 32'd1);
    while (pulse_active && i < 4000) begin
      check_pins(req);
      tick = tick_pat(pat, i);
      trig = retrig && (i % 5 == 1);
      if (midwrite && i == 2) begin
        cfg_we = 1'b1; cfg_wdata = {m_lvl ? 8'hA5 : 8'h5A, 4'h0, 20'd3};
      end else begin
        cfg_we = 1'b0; cfg_wdata = '0;
      end
      if (tick) ticks++;
      i++;
      @(negedge clk);
      if (midwrite && i == 3) m_len = 20'd3;
    end
    trig = 1'b0; tick = 1'b0; cfg_we = 1'b0;
    check({req, " tick count"}, ticks, exp_ticks);
    check_pins(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    m_lvl = 1'b0; m_drv = 1'b0; m_len = 20'd255;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 word", cfg_rdata, 32'h0000_00FF);
    check("R1 active", {31'd0, pulse_active}, 32'd0);
    check("R1 rst_out", {31'd0, rst_out}, 32'd1);
    check("R1 rst_oe", {31'd0, rst_oe}, 32'd0);

    // R8 default length pulse, R10 R11 on pins
    run_pulse(0, 256, 1'b0, 1'b0, "R8 default");

    // R2..R7 sweep every top byte from each flag state
    for (int st = 0; st < 4; st++) begin
      wr({st[1] ? 8'hA5 : 8'h5A, 24'd0});
      wr({st[0] ? 8'hA8 : 8'h8A, 24'd0});
      check("R3 R4 R5 R6 preset", cfg_rdata, model_word());
      for (int k = 0; k < 256; k++) begin
        logic [31:0] d;
        string tag;
        d = {k[7:0], k[3:0], 20'((k * 4099 + st * 77) & 20'hFFFFF)};
        wr(d);
        case (k)
          8'hA5: tag = "R3";
          8'h5A: tag = "R4";
          8'hA8: tag = "R5";
          8'h8A: tag = "R6";
          default: tag = "R7 R2";
        endcase
        check(tag, cfg_rdata, model_word());
        check_pins("R11 idle");
      end
    end

    // R8 R10 R11 over all flag states and short lengths with tick patterns
    for (int st = 0; st < 4; st++) begin
      for (int w = 0; w < 12; w++) begin
        wr({st[1] ? 8'hA5 : 8'h5A, 24'(w)});
        wr({st[0] ? 8'hA8 : 8'h8A, 24'(w)});
        run_pulse(w % 3, w + 1, 1'b0, 1'b0, w == 0 ? "R12 zero len" : "R8 length");
      end
    end

    // R9 retrigger during pulse ignored
    wr({8'hA5, 24'd20});
    run_pulse(1, 21, 1'b1, 1'b0, "R9 retrigger");
    run_pulse(0, 21, 1'b1, 1'b0, "R9 back to back");

    // R12 length write during a pulse does not affect it
    wr({8'h5A, 24'd15});
    run_pulse(2, 16, 1'b0, 1'b1, "R12 midwrite");
    check("R12 new len", cfg_rdata, model_word());
    run_pulse(0, 4, 1'b0, 1'b0, "R12 next pulse");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule